// File: doc/BRIEF.md
# Register Window State Controller

This block keeps the bookkeeping for a windowed integer register file. It holds the current window pointer and four occupancy counters. The save-capacity counter counts windows free for a new call frame. The restore-capacity counter counts windows that hold the caller's frames. The foreign-window counter counts windows that belong to another address space. The clean-window counter counts windows whose contents are known to be safe to hand out. The window count is a parameter.

Each cycle the controller takes at most one command: save, restore, saved, restored or flush. It either advances its state or reports a trap in the following cycle, with a type code and a vector offset. The offset is drawn from one of two 3-bit fields of a 6-bit window-state input. A load port sets every register at once, for example after a context switch. On reset the block comes up with a full set of saveable windows.

Top module: `wnd_state_ctrl`

## Requirements
- R1: When reset is released, cwp is 0, cansave is NWIN-2, canrestore is 0, otherwin is 0, cleanwin is NWIN-1 and trap_valid is 0.
- R2: Command code 1 (save) with cansave nonzero and cleanwin not equal to canrestore sets cwp to cwp+1 modulo NWIN, decrements cansave and increments canrestore, with no trap.
- R3: Save with cansave equal to 0 raises a spill trap. If otherwin is nonzero the trap has type code 1 and offset 4×wstate[5:3]. Otherwise it has type code 0 and offset 4×wstate[2:0].
- R4: Save with cansave nonzero and cleanwin equal to canrestore raises a clean-window trap with type code 4 and offset 0.
- R5: Command code 2 (restore) with canrestore nonzero sets cwp to cwp-1 modulo NWIN, increments cansave and decrements canrestore, with no trap.
- R6: Restore with canrestore equal to 0 raises a fill trap. If otherwin is nonzero the trap has type code 3 and offset 4×wstate[5:3]. Otherwise it has type code 2 and offset 4×wstate[2:0].
- R7: Command code 3 (saved) increments cansave. It then decrements canrestore if otherwin is 0, or decrements otherwin otherwise. It never traps.
- R8: Command code 4 (restored) increments canrestore. It then decrements cansave if otherwin is 0, or decrements otherwin otherwise. It increments cleanwin only while cleanwin is below NWIN-1, and it never traps.
- R9: Command code 5 (flush) raises a spill trap with the R3 type and offset selection whenever cansave differs from NWIN-2. Otherwise it has no effect.
- R10: A trapping command leaves every state register unchanged. trap_valid, trap_kind and trap_offset appear in the cycle after the command, and trap_valid stays high for that one cycle only unless another command traps.
- R11: ld_en loads all five registers from the ld_* inputs in the next cycle. Any command in the same cycle is ignored and raises no trap. Command code 0 is idle and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Command code (0 idle, 1 save, 2 restore, 3 saved, 4 restored, 5 flush) |
| wstate | input | 6 | Trap offset select: [5:3] for foreign-window traps, [2:0] for normal ones |
| ld_en | input | 1 | Load all state registers |
| ld_cwp | input | CW | Window pointer to load |
| ld_cansave | input | CW | Save-capacity value to load |
| ld_canrestore | input | CW | Restore-capacity value to load |
| ld_otherwin | input | CW | Foreign-window value to load |
| ld_cleanwin | input | CW | Clean-window value to load |
| cwp | output | CW | Current window pointer |
| cansave | output | CW | Save-capacity counter |
| canrestore | output | CW | Restore-capacity counter |
| otherwin | output | CW | Foreign-window counter |
| cleanwin | output | CW | Clean-window counter |
| trap_valid | output | 1 | Trap reported for the previous command |
| trap_kind | output | 3 | Trap type code (0 spill normal, 1 spill other, 2 fill normal, 3 fill other, 4 clean window) |
| trap_offset | output | 5 | Trap vector offset |

## Verification
Save and restore are each tried from states that succeed, from states at the pointer wrap, and from states that trap. The trapping states are set up with otherwin zero and nonzero and with different values in the two wstate fields, so a swapped field or a swapped kind shows up. The saved and restored commands are each applied with otherwin zero and nonzero, which separates the two counter paths. Restored is repeated until cleanwin reaches its ceiling, which exposes a missing or misplaced saturation. Flush is applied both at exactly NWIN-2 saveable windows and below it. A load applied together with a command shows whether the load takes priority.

// File: rtl/wnd_pkg.sv
// Package: shared command and trap encodings for the window state controller.
// Assumes a 3-bit command bus and a 3-bit trap type code.
package wnd_pkg;
    typedef enum logic [2:0] {
        CMD_IDLE     = 3'd0,
        CMD_SAVE     = 3'd1,
        CMD_RESTORE  = 3'd2,
        CMD_SAVED    = 3'd3,
        CMD_RESTORED = 3'd4,
        CMD_FLUSH    = 3'd5
    } wnd_cmd_e;

    typedef enum logic [2:0] {
        TRAP_SPILL_NORM = 3'd0,
        TRAP_SPILL_OTH  = 3'd1,
        TRAP_FILL_NORM  = 3'd2,
        TRAP_FILL_OTH   = 3'd3,
        TRAP_CLEAN      = 3'd4
    } wnd_trap_e;
endpackage

// File: rtl/wnd_trap_sel.sv
// Module: wnd_trap_sel
// Picks the spill or fill trap type and its vector offset. A nonzero
// foreign-window count selects the "other" variant and the upper wstate
// field. Otherwise the normal variant and the lower field are used.
// Assumes offsets are the chosen 3-bit field scaled by 4.
module wnd_trap_sel
    import wnd_pkg::*;
(
    input  logic      is_fill,
    input  logic      other_nz,
    input  logic [5:0] wstate,
    output wnd_trap_e kind,
    output logic [4:0] offset
);
    // Kind and offset selection from direction and foreign-window presence.
    always_comb begin
        if (other_nz) begin
            kind   = is_fill ? TRAP_FILL_OTH : TRAP_SPILL_OTH;
            offset = {wstate[5:3], 2'b00};
        end else begin
            kind   = is_fill ? TRAP_FILL_NORM : TRAP_SPILL_NORM;
            offset = {wstate[2:0], 2'b00};
        end
    end
endmodule

// File: rtl/wnd_step.sv
// Module: wnd_step
// Combinational next-state logic for one command. It produces the
// successor register values, or a trap request that leaves them unchanged.
// Assumes that counter values stay within 0..NWIN-1.
module wnd_step
    import wnd_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
)(
    input  logic [2:0]    cmd,
    input  logic [5:0]    wstate,
    input  logic [CW-1:0] cur_cwp,
    input  logic [CW-1:0] cur_cs,
    input  logic [CW-1:0] cur_cr,
    input  logic [CW-1:0] cur_ow,
    input  logic [CW-1:0] cur_cw,
    output logic [CW-1:0] nxt_cwp,
    output logic [CW-1:0] nxt_cs,
    output logic [CW-1:0] nxt_cr,
    output logic [CW-1:0] nxt_ow,
    output logic [CW-1:0] nxt_cw,
    output logic          trap_req,
    output wnd_trap_e     trap_kind,
    output logic [4:0]    trap_off
);
    localparam logic [CW-1:0] LAST  = CW'(NWIN - 1);
    localparam logic [CW-1:0] FULLS = CW'(NWIN - 2);
    localparam logic [CW-1:0] ONE   = CW'(1);

    wnd_cmd_e      op;
    logic          ow_nz;
    wnd_trap_e     sel_kind;
    logic [4:0]    sel_off;
    logic [CW-1:0] cwp_inc;
    logic [CW-1:0] cwp_dec;

    assign op    = wnd_cmd_e'(cmd);
    assign ow_nz = (cur_ow != '0);

    // Modulo-NWIN neighbours of the window pointer.
    always_comb begin
        cwp_inc = (cur_cwp == LAST) ? '0 : cur_cwp + ONE;
        cwp_dec = (cur_cwp == '0) ? LAST : cur_cwp - ONE;
    end

    wnd_trap_sel u_sel (
        .is_fill  (op == CMD_RESTORE),
        .other_nz (ow_nz),
        .wstate   (wstate),
        .kind     (sel_kind),
        .offset   (sel_off)
    );

    // Command decode: successor state, or a trap that freezes the state.
    always_comb begin
        nxt_cwp   = cur_cwp;
        nxt_cs    = cur_cs;
        nxt_cr    = cur_cr;
        nxt_ow    = cur_ow;
        nxt_cw    = cur_cw;
        trap_req  = 1'b0;
        trap_kind = TRAP_CLEAN;
        trap_off  = '0;
        case (op)
            CMD_SAVE: begin
                if (cur_cs == '0) begin
                    trap_req  = 1'b1;
                    trap_kind = sel_kind;
                    trap_off  = sel_off;
                end else if (cur_cw == cur_cr) begin
                    trap_req  = 1'b1;
                    trap_kind = TRAP_CLEAN;
                    trap_off  = '0;
                end else begin
                    nxt_cwp = cwp_inc;
                    nxt_cs  = cur_cs - ONE;
                    nxt_cr  = cur_cr + ONE;
                end
            end
            CMD_RESTORE: begin
                if (cur_cr == '0) begin
                    trap_req  = 1'b1;
                    trap_kind = sel_kind;
                    trap_off  = sel_off;
                end else begin
                    nxt_cwp = cwp_dec;
                    nxt_cs  = cur_cs + ONE;
                    nxt_cr  = cur_cr - ONE;
                end
            end
            CMD_SAVED: begin
                nxt_cs = cur_cs + ONE;
                if (ow_nz) nxt_ow = cur_ow - ONE;
                else       nxt_cr = cur_cr - ONE;
            end
            CMD_RESTORED: begin
                nxt_cr = cur_cr + ONE;
                if (ow_nz) nxt_ow = cur_ow - ONE;
                else       nxt_cs = cur_cs - ONE;
                if (cur_cw < LAST) nxt_cw = cur_cw + ONE;
            end
            CMD_FLUSH: begin
                if (cur_cs != FULLS) begin
                    trap_req  = 1'b1;
                    trap_kind = sel_kind;
                    trap_off  = sel_off;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wnd_state_ctrl.sv
// Module: wnd_state_ctrl (top)
// Holds the window pointer and the four occupancy counters, and applies one
// command per cycle through wnd_step. A load port takes priority over any
// command. Trap reports are registered and appear one cycle after the
// command. Assumes NWIN >= 3.
module wnd_state_ctrl
    import wnd_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cmd,
    input  logic [5:0]    wstate,
    input  logic          ld_en,
    input  logic [CW-1:0] ld_cwp,
    input  logic [CW-1:0] ld_cansave,
    input  logic [CW-1:0] ld_canrestore,
    input  logic [CW-1:0] ld_otherwin,
    input  logic [CW-1:0] ld_cleanwin,
    output logic [CW-1:0] cwp,
    output logic [CW-1:0] cansave,
    output logic [CW-1:0] canrestore,
    output logic [CW-1:0] otherwin,
    output logic [CW-1:0] cleanwin,
    output logic          trap_valid,
    output logic [2:0]    trap_kind,
    output logic [4:0]    trap_offset
);
    logic [CW-1:0] n_cwp, n_cs, n_cr, n_ow, n_cw;
    logic          n_trap;
    wnd_trap_e     n_kind;
    logic [4:0]    n_off;

    wnd_step #(.NWIN(NWIN)) u_step (
        .cmd       (cmd),
        .wstate    (wstate),
        .cur_cwp   (cwp),
        .cur_cs    (cansave),
        .cur_cr    (canrestore),
        .cur_ow    (otherwin),
        .cur_cw    (cleanwin),
        .nxt_cwp   (n_cwp),
        .nxt_cs    (n_cs),
        .nxt_cr    (n_cr),
        .nxt_ow    (n_ow),
        .nxt_cw    (n_cw),
        .trap_req  (n_trap),
        .trap_kind (n_kind),
        .trap_off  (n_off)
    );

    // State and trap registers: reset, then load, then command result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp         <= '0;
            cansave     <= CW'(NWIN - 2);
            canrestore  <= '0;
            otherwin    <= '0;
            cleanwin    <= CW'(NWIN - 1);
            trap_valid  <= 1'b0;
            trap_kind   <= '0;
            trap_offset <= '0;
        end else if (ld_en) begin
            cwp         <= ld_cwp;
            cansave     <= ld_cansave;
            canrestore  <= ld_canrestore;
            otherwin    <= ld_otherwin;
            cleanwin    <= ld_cleanwin;
            trap_valid  <= 1'b0;
        end else begin
            cwp         <= n_cwp;
            cansave     <= n_cs;
            canrestore  <= n_cr;
            otherwin    <= n_ow;
            cleanwin    <= n_cw;
            trap_valid  <= n_trap;
            if (n_trap) begin
                trap_kind   <= n_kind;
                trap_offset <= n_off;
            end
        end
    end
endmodule

// File: rtl/wnd_state_ctrl_chk.sv
// Module: wnd_state_ctrl_chk
// Temporal checks on the controller ports, attached by bind.
module wnd_state_ctrl_chk #(
    parameter int NWIN = 8,
    localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
)(
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cmd,
    input logic          ld_en,
    input logic [CW-1:0] ld_cwp,
    input logic [CW-1:0] cwp,
    input logic [CW-1:0] cansave,
    input logic [CW-1:0] canrestore,
    input logic [CW-1:0] otherwin,
    input logic [CW-1:0] cleanwin,
    input logic          trap_valid,
    input logic [2:0]    trap_kind
);
    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    // R10: a trap freezes every state register
    a_r10_trap_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && trap_valid) |->
        (cwp == $past(cwp) && cansave == $past(cansave) &&
         canrestore == $past(canrestore) && otherwin == $past(otherwin) &&
         cleanwin == $past(cleanwin)));

    // R2: a successful save steps the pointer forward with wrap
    a_r2_save_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd) == 3'd1 && !$past(ld_en) && !trap_valid) |->
        (cwp == (($past(cwp) == LAST) ? '0 : CW'($past(cwp) + 1'b1)) &&
         cansave == CW'($past(cansave) - 1'b1)));

    // R5: a successful restore steps the pointer back with wrap
    a_r5_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd) == 3'd2 && !$past(ld_en) && !trap_valid) |->
        (cwp == (($past(cwp) == '0) ? LAST : CW'($past(cwp) - 1'b1)) &&
         cansave == CW'($past(cansave) + 1'b1)));

    // R6: fill traps only follow a restore command
    a_r6_fill_source: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && trap_valid && (trap_kind == 3'd2 || trap_kind == 3'd3)) |->
        ($past(cmd) == 3'd2));

    // R8: restored raises cleanwin with a ceiling at NWIN-1
    a_r8_clean_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd) == 3'd4 && !$past(ld_en)) |->
        (cleanwin == (($past(cleanwin) < LAST) ? CW'($past(cleanwin) + 1'b1)
                                               : $past(cleanwin))));

    // R9: flush with NWIN-2 saveable windows is quiet
    a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd) == 3'd5 && !$past(ld_en) &&
         $past(cansave) == CW'(NWIN - 2)) |-> !trap_valid);

    // R11: a load wins over any command
    a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_en)) |-> (cwp == $past(ld_cwp) && !trap_valid));
endmodule

bind wnd_state_ctrl wnd_state_ctrl_chk #(.NWIN(NWIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .ld_en      (ld_en),
    .ld_cwp     (ld_cwp),
    .cwp        (cwp),
    .cansave    (cansave),
    .canrestore (canrestore),
    .otherwin   (otherwin),
    .cleanwin   (cleanwin),
    .trap_valid (trap_valid),
    .trap_kind  (trap_kind)
);

// File: tb/tb_wnd_state_ctrl.sv
// Directed bench for wnd_state_ctrl with NWIN = 8.
module tb_wnd_state_ctrl;
    localparam int NWIN = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd = 3'd0;
    logic [5:0]    wstate = 6'b101_011;
    logic          ld_en = 1'b0;
    logic [CW-1:0] ld_cwp = '0, ld_cs = '0, ld_cr = '0, ld_ow = '0, ld_cw = '0;
    logic [CW-1:0] cwp, cansave, canrestore, otherwin, cleanwin;
    logic          trap_valid;
    logic [2:0]    trap_kind;
    logic [4:0]    trap_offset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wnd_state_ctrl #(.NWIN(NWIN)) dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .wstate(wstate), .ld_en(ld_en),
        .ld_cwp(ld_cwp), .ld_cansave(ld_cs), .ld_canrestore(ld_cr),
        .ld_otherwin(ld_ow), .ld_cleanwin(ld_cw),
        .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
        .otherwin(otherwin), .cleanwin(cleanwin),
        .trap_valid(trap_valid), .trap_kind(trap_kind), .trap_offset(trap_offset)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare all five registers at once against expected values.
    task automatic chk_state(input string req, input int c, input int s,
                             input int r, input int o, input int w);
        chk({req, " cwp"}, cwp, c);
        chk({req, " cansave"}, cansave, s);
        chk({req, " canrestore"}, canrestore, r);
        chk({req, " otherwin"}, otherwin, o);
        chk({req, " cleanwin"}, cleanwin, w);
    endtask

    task automatic load(input int c, input int s, input int r, input int o, input int w);
        @(negedge clk);
        ld_en = 1'b1; ld_cwp = CW'(c); ld_cs = CW'(s); ld_cr = CW'(r);
        ld_ow = CW'(o); ld_cw = CW'(w);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Apply one command for one cycle; results are visible at the next negedge.
    task automatic issue(input logic [2:0] c);
        @(negedge clk);
        cmd = c;
        @(negedge clk);
        cmd = 3'd0;
    endtask

    task automatic t_reset();
        chk_state("R1 reset", 0, 6, 0, 0, 7);
        chk("R1 trap_valid", trap_valid, 0);
    endtask

    task automatic t_save_restore();
        issue(3'd1);
        chk("R2 no trap", trap_valid, 0);
        chk_state("R2 save", 1, 5, 1, 0, 7);
        issue(3'd2);
        chk("R5 no trap", trap_valid, 0);
        chk_state("R5 restore", 0, 6, 0, 0, 7);
        load(7, 5, 1, 0, 7);
        issue(3'd1);
        chk("R2 wrap cwp", cwp, 0);
        issue(3'd2);
        chk("R5 wrap cwp", cwp, 7);
    endtask

    task automatic t_spill();
        load(5, 0, 3, 2, 7);
        issue(3'd1);
        chk("R3 other trap", trap_valid, 1);
        chk("R3 other kind", trap_kind, 1);
        chk("R3 other offset", trap_offset, 20);
        chk_state("R10 spill frozen", 5, 0, 3, 2, 7);
        @(negedge clk);
        chk("R10 one cycle", trap_valid, 0);
        load(5, 0, 3, 0, 7);
        issue(3'd1);
        chk("R3 normal kind", trap_kind, 0);
        chk("R3 normal offset", trap_offset, 12);
    endtask

    task automatic t_clean();
        load(2, 3, 2, 0, 2);
        issue(3'd1);
        chk("R4 trap", trap_valid, 1);
        chk("R4 kind", trap_kind, 4);
        chk("R4 offset", trap_offset, 0);
        chk_state("R10 clean frozen", 2, 3, 2, 0, 2);
    endtask

    task automatic t_fill();
        load(3, 6, 0, 0, 7);
        issue(3'd2);
        chk("R6 normal trap", trap_valid, 1);
        chk("R6 normal kind", trap_kind, 2);
        chk("R6 normal offset", trap_offset, 12);
        chk_state("R10 fill frozen", 3, 6, 0, 0, 7);
        load(3, 5, 0, 1, 7);
        issue(3'd2);
        chk("R6 other kind", trap_kind, 3);
        chk("R6 other offset", trap_offset, 20);
    endtask

    task automatic t_saved();
        load(1, 2, 3, 0, 7);
        issue(3'd3);
        chk("R7 no trap", trap_valid, 0);
        chk_state("R7 ow zero", 1, 3, 2, 0, 7);
        load(1, 2, 3, 1, 7);
        issue(3'd3);
        chk_state("R7 ow set", 1, 3, 3, 0, 7);
    endtask

    task automatic t_restored();
        load(0, 3, 2, 0, 5);
        issue(3'd4);
        chk_state("R8 step1", 0, 2, 3, 0, 6);
        issue(3'd4);
        chk_state("R8 step2", 0, 1, 4, 0, 7);
        issue(3'd4);
        chk_state("R8 ceiling", 0, 0, 5, 0, 7);
        chk("R8 no trap", trap_valid, 0);
        load(0, 3, 2, 1, 4);
        issue(3'd4);
        chk_state("R8 ow set", 0, 3, 3, 0, 5);
    endtask

    task automatic t_flush();
        load(4, 6, 0, 0, 7);
        issue(3'd5);
        chk("R9 quiet", trap_valid, 0);
        chk_state("R9 unchanged", 4, 6, 0, 0, 7);
        load(4, 4, 2, 1, 7);
        issue(3'd5);
        chk("R9 trap", trap_valid, 1);
        chk("R9 kind", trap_kind, 1);
        chk("R9 offset", trap_offset, 20);
        chk_state("R9 frozen", 4, 4, 2, 1, 7);
    endtask

    task automatic t_load_priority();
        @(negedge clk);
        ld_en = 1'b1; cmd = 3'd2;
        ld_cwp = 3'd6; ld_cs = 3'd1; ld_cr = 3'd0; ld_ow = 3'd0; ld_cw = 3'd3;
        @(negedge clk);
        ld_en = 1'b0; cmd = 3'd0;
        chk("R11 no trap", trap_valid, 0);
        chk_state("R11 load", 6, 1, 0, 0, 3);
        issue(3'd0);
        chk_state("R11 idle", 6, 1, 0, 0, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_save_restore();
        t_spill();
        t_clean();
        t_fill();
        t_saved();
        t_restored();
        t_flush();
        t_load_priority();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule